// File: doc/BRIEF.md
# Periodic and One-Shot Comparator Channel

This block is a single timer channel. A free-running main counter, kept outside the block, is presented on `count_i`. The channel holds a 64-bit comparator and raises a one-cycle strobe on `fire_o` when the counter reaches it. The strobe goes to interrupt logic that is also outside the block. In one-shot mode the channel fires once per arming. In periodic mode it also keeps a hidden period value, and every match moves the comparator forward by that period.

Software reaches the channel through three write strobes: one for the configuration word and one for each 32-bit half of the comparator. A narrow mode makes the channel work on the low 32 bits only. In narrow one-shot mode the channel gives an extra strobe when the counter rolls over past all-ones before the match. A set-value flag lets software place the comparator directly while the channel is periodic. The flag clears itself after one comparator write.

Top module: `tmr_cmp_chan`

## Requirements
- R1: After reset the comparator reads all-ones, the period is zero and `fire_o` is low.
- R2: In one-shot mode an armed channel pulses `fire_o` for one cycle, one clock after the sampled counter first reaches the comparator. It stays quiet after that until it is re-armed (channel enable 0→1, global enable 0→1, or a comparator write while enabled).
- R3: "Reached" means the signed difference counter − comparator is not negative. This is 32 bits wide in narrow mode, where upper counter bits are ignored, and 64 bits wide otherwise.
- R4: In periodic mode with a non-zero period, each match pulses `fire_o`, and the comparator gains the period in the same edge. In narrow mode the sum is cut to 32 bits.
- R5: A periodic channel whose comparator lags the counter by several periods fires once, then steps the comparator by one period per cycle until it is ahead.
- R6: A low-half comparator write changes the comparator only when the channel is one-shot or set-value is armed. In periodic mode the written word also loads the low half of the period.
- R7: Set-value (config bit 6) clears after any comparator-half write. Config bit 2 is channel enable and bit 3 selects periodic mode.
- R8: The sign bit of a stored period is forced to zero: bit 31 on a low-half write in narrow mode, and bit 63 on every high-half write.
- R9: Selecting narrow mode (config bit 8) clears the upper 32 bits of comparator and period. While narrow, high-half writes leave both unchanged.
- R10: In narrow one-shot mode, if at arming the distance to the counter's 32-bit roll-over is shorter than the distance to the match, the channel also fires when the counter's low half is all-ones, then again at the match.
- R11: The channel never fires while its enable or the global enable is low. A 1→0 enable disarms it.
- R12: A cycle carrying any register write neither fires nor advances. Matching is re-evaluated on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Main counter value |
| gbl_en_i | input | 1 | Global enable for all channels |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 9 | Configuration word (bit 2 enable, 3 periodic, 6 set-value, 8 narrow) |
| cmp_lo_we_i | input | 1 | Comparator low-half write strobe |
| cmp_hi_we_i | input | 1 | Comparator high-half write strobe |
| cmp_wdata_i | input | 32 | Comparator write word |
| fire_o | output | 1 | One-cycle expiry strobe |
| cmp_o | output | 64 | Current comparator value |

## Verification
Two events can land in the same cycle: a comparator write, and the periodic match that would move the comparator. The bench drives the counter onto the comparator in the same cycle as a low-half period write. It expects the strobe one cycle later than a plain match would give, and it expects exactly one period step on the comparator. This shows that the write won the collision and the match was then taken once from the updated state.

// File: rtl/chan_cmp_pkg.sv
package chan_cmp_pkg;

  localparam int CNT_W  = 64;
  localparam int HALF_W = CNT_W / 2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic narrow;
    logic setval;
    logic periodic;
    logic en;
  } chan_cfg_t;

  // counter has reached comparator: signed difference is non-negative
  function automatic logic has_reached(cnt_t cnt, cnt_t cmp, logic narrow);
    cnt_t d;
    d = cnt - cmp;
    return narrow ? ~d[HALF_W-1] : ~d[CNT_W-1];
  endfunction

  // comparator after one period step
  function automatic cnt_t next_cmp(cnt_t cmp, cnt_t per, logic narrow);
    cnt_t s;
    s = cmp + per;
    if (narrow) s[CNT_W-1:HALF_W] = '0;
    return s;
  endfunction

  // narrow one-shot: does the low half roll over before the match?
  function automatic logic wrap_before_match(logic [HALF_W-1:0] cnt_lo,
                                             logic [HALF_W-1:0] cmp_lo);
    logic [HALF_W-1:0] gap;
    logic [HALF_W-1:0] to_wrap;
    gap = cmp_lo - cnt_lo;
    if (gap[HALF_W-1]) gap = '0;
    to_wrap = ~cnt_lo;
    return to_wrap < gap;
  endfunction

  function automatic cnt_t low_half(cnt_t v);
    return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

endpackage

// File: rtl/chan_cmp_regs.sv
module chan_cmp_regs
  import chan_cmp_pkg::*;
#(
  parameter int CFG_W   = 9,
  parameter int EN_POS  = 2,
  parameter int PER_POS = 3,
  parameter int SET_POS = 6,
  parameter int NAR_POS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              adv_i,
  output chan_cfg_t         cfg_o,
  output chan_cfg_t         cfg_nx_o,
  output cnt_t              cmp_o,
  output logic [HALF_W-1:0] cmp_nx_lo_o,
  output cnt_t              per_o,
  output logic              wr_o,
  output logic              arm_o,
  output logic              disarm_o
);

  chan_cfg_t cfg_q, cfg_d;
  cnt_t      cmp_q, cmp_d;
  cnt_t      per_q, per_d;
  logic [HALF_W-1:0] per_word;

  always_comb begin
    cfg_d    = cfg_q;
    cmp_d    = cmp_q;
    per_d    = per_q;
    per_word = wdata_i;
    if (cfg_q.narrow) per_word[HALF_W-1] = 1'b0;

    if (cfg_we_i) begin
      cfg_d.en       = cfg_wdata_i[EN_POS];
      cfg_d.periodic = cfg_wdata_i[PER_POS];
      cfg_d.setval   = cfg_wdata_i[SET_POS];
      cfg_d.narrow   = cfg_wdata_i[NAR_POS];
      if (cfg_d.narrow) begin
        cmp_d = low_half(cmp_q);
        per_d = low_half(per_q);
      end
    end else if (lo_we_i) begin
      if (!cfg_q.periodic || cfg_q.setval) cmp_d[HALF_W-1:0] = wdata_i;
      if (cfg_q.periodic) per_d[HALF_W-1:0] = per_word;
      cfg_d.setval = 1'b0;
    end else if (hi_we_i) begin
      if (!cfg_q.narrow) begin
        if (!cfg_q.periodic || cfg_q.setval) cmp_d[CNT_W-1:HALF_W] = wdata_i;
        else per_d[CNT_W-1:HALF_W] = {1'b0, wdata_i[HALF_W-2:0]};
      end
      cfg_d.setval = 1'b0;
    end else if (adv_i) begin
      cmp_d = next_cmp(cmp_q, per_q, cfg_q.narrow);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      cmp_q <= cmp_d;
      per_q <= per_d;
    end
  end

  assign wr_o     = cfg_we_i | lo_we_i | hi_we_i;
  assign arm_o    = (cfg_we_i && !cfg_q.en && cfg_wdata_i[EN_POS]) ||
                    (!cfg_we_i && (lo_we_i || hi_we_i) && cfg_q.en);
  assign disarm_o = cfg_we_i && cfg_q.en && !cfg_wdata_i[EN_POS];

  assign cfg_o       = cfg_q;
  assign cfg_nx_o    = cfg_d;
  assign cmp_o       = cmp_q;
  assign cmp_nx_lo_o = cmp_d[HALF_W-1:0];
  assign per_o       = per_q;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata_i;

  // R6: periodic low write without set-value leaves comparator alone
  p_lo_keeps_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we_i && !cfg_we_i && cfg_q.periodic && !cfg_q.setval) |=> $stable(cmp_q));

  // R7: set-value is gone after any comparator write
  p_setval_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_we_i || hi_we_i) && !cfg_we_i) |=> !cfg_q.setval);

  // R8: stored period never carries bit 63
  p_period_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !per_q[CNT_W-1]);

  // R9: narrow mode keeps comparator and period upper halves clear
  p_narrow_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.narrow |-> (cmp_q[CNT_W-1:HALF_W] == '0 && per_q[CNT_W-1:HALF_W] == '0));

endmodule

// File: rtl/chan_cmp_match.sv
module chan_cmp_match
  import chan_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cnt_t              count_i,
  input  logic              gbl_en_i,
  input  chan_cfg_t         cfg_i,
  input  chan_cfg_t         cfg_nx_i,
  input  cnt_t              cmp_i,
  input  logic [HALF_W-1:0] cmp_nx_lo_i,
  input  cnt_t              per_i,
  input  logic              wr_i,
  input  logic              arm_i,
  input  logic              disarm_i,
  output logic              fire_o,
  output logic              adv_o
);

  logic gbl_q, done_q, lag_q, wrap_q, fire_q;
  logic gbl_rise, active, settle, due, per_mode, still_due;
  logic match_hit, wrap_hit, arm_any;

  assign gbl_rise  = gbl_en_i & ~gbl_q;
  assign active    = gbl_en_i & cfg_i.en;
  assign settle    = wr_i | gbl_rise;
  assign due       = has_reached(count_i, cmp_i, cfg_i.narrow);
  assign per_mode  = cfg_i.periodic && (per_i != '0);
  assign still_due = has_reached(count_i, next_cmp(cmp_i, per_i, cfg_i.narrow), cfg_i.narrow);

  assign adv_o     = active & ~settle & per_mode & due;
  assign match_hit = active & ~settle & due & (per_mode ? ~lag_q : ~done_q);
  assign wrap_hit  = active & ~settle & cfg_i.narrow & ~cfg_i.periodic & wrap_q &
                     (&count_i[HALF_W-1:0]);
  assign arm_any   = arm_i | (gbl_rise & cfg_nx_i.en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gbl_q  <= 1'b0;
      done_q <= 1'b0;
      lag_q  <= 1'b0;
      wrap_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      gbl_q  <= gbl_en_i;
      fire_q <= match_hit | wrap_hit;
      lag_q  <= adv_o & still_due;
      if (arm_any) done_q <= 1'b0;
      else if (match_hit & ~per_mode) done_q <= 1'b1;
      if (disarm_i) wrap_q <= 1'b0;
      else if (arm_any)
        wrap_q <= cfg_nx_i.narrow & ~cfg_nx_i.periodic &
                  wrap_before_match(count_i[HALF_W-1:0], cmp_nx_lo_i);
      else if (wrap_hit) wrap_q <= 1'b0;
    end
  end

  assign fire_o = fire_q;

  logic unused_setval;
  assign unused_setval = cfg_i.setval ^ cfg_nx_i.setval;

  // R11: a strobe only follows a cycle with both enables high
  p_fire_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(gbl_en_i && cfg_i.en));

  // R12: a write cycle is never followed by a strobe
  p_write_blocks_fire_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !fire_q);

  // R5: catch-up steps after the first are silent
  p_catchup_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_o && lag_q) |=> !fire_q);

  // R10: roll-over strobe only with narrow one-shot configuration
  p_wrap_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_q && !$past(due)) |-> $past(cfg_i.narrow && !cfg_i.periodic));

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import chan_cmp_pkg::*;
#(
  parameter int CFG_W   = 9,
  parameter int EN_POS  = 2,
  parameter int PER_POS = 3,
  parameter int SET_POS = 6,
  parameter int NAR_POS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              gbl_en_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              cmp_lo_we_i,
  input  logic              cmp_hi_we_i,
  input  logic [HALF_W-1:0] cmp_wdata_i,
  output logic              fire_o,
  output logic [CNT_W-1:0]  cmp_o
);

  chan_cfg_t         cfg_q, cfg_nx;
  cnt_t              cmp_q, per_q;
  logic [HALF_W-1:0] cmp_nx_lo;
  logic              wr, arm, disarm, adv;

  chan_cmp_regs #(
    .CFG_W  (CFG_W),
    .EN_POS (EN_POS),
    .PER_POS(PER_POS),
    .SET_POS(SET_POS),
    .NAR_POS(NAR_POS)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .lo_we_i    (cmp_lo_we_i),
    .hi_we_i    (cmp_hi_we_i),
    .wdata_i    (cmp_wdata_i),
    .adv_i      (adv),
    .cfg_o      (cfg_q),
    .cfg_nx_o   (cfg_nx),
    .cmp_o      (cmp_q),
    .cmp_nx_lo_o(cmp_nx_lo),
    .per_o      (per_q),
    .wr_o       (wr),
    .arm_o      (arm),
    .disarm_o   (disarm)
  );

  chan_cmp_match match_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (count_i),
    .gbl_en_i   (gbl_en_i),
    .cfg_i      (cfg_q),
    .cfg_nx_i   (cfg_nx),
    .cmp_i      (cmp_q),
    .cmp_nx_lo_i(cmp_nx_lo),
    .per_i      (per_q),
    .wr_i       (wr),
    .arm_i      (arm),
    .disarm_i   (disarm),
    .fire_o     (fire_o),
    .adv_o      (adv)
  );

  assign cmp_o = cmp_q;

endmodule

// File: tb/tmr_cmp_chan_tb.sv
`timescale 1ns/1ps
module tmr_cmp_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count = '0;
  logic        gbl_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_wdata = '0;
  logic        lo_we = 1'b0;
  logic        hi_we = 1'b0;
  logic [31:0] cmp_wdata = '0;
  logic        fire;
  logic [63:0] cmp_val;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int    exp_cyc[$];
  string exp_req[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_cmp_chan dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (count),
    .gbl_en_i   (gbl_en),
    .cfg_we_i   (cfg_we),
    .cfg_wdata_i(cfg_wdata),
    .cmp_lo_we_i(lo_we),
    .cmp_hi_we_i(hi_we),
    .cmp_wdata_i(cmp_wdata),
    .fire_o     (fire),
    .cmp_o      (cmp_val)
  );

  // scoreboard monitor: strobes are matched against expected cycles
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      while (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s: missed strobe, actual=0 expected=1 at cycle %0d", exp_req[0], exp_cyc[0]);
        void'(exp_cyc.pop_front()); void'(exp_req.pop_front());
      end
      if (fire) begin
        checks++;
        if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
          void'(exp_cyc.pop_front()); void'(exp_req.pop_front());
        end else begin
          errors++;
          $display("FAIL %s: unexpected strobe at cycle %0d, actual=1 expected=0",
                   (exp_req.size() > 0) ? exp_req[0] : "R2", cyc);
        end
      end
    end
  end

  task automatic expect_at(int c, string req);
    exp_cyc.push_back(c);
    exp_req.push_back(req);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(bit en, bit per, bit sv, bit nar, bit fires = 0, string req = "");
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = '0;
    cfg_wdata[2] = en; cfg_wdata[3] = per; cfg_wdata[6] = sv; cfg_wdata[8] = nar;
    if (fires) expect_at(cyc + 2, req);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_lo(logic [31:0] v);
    @(negedge clk); lo_we = 1'b1; cmp_wdata = v;
    @(negedge clk); lo_we = 1'b0;
  endtask

  task automatic wr_hi(logic [31:0] v);
    @(negedge clk); hi_we = 1'b1; cmp_wdata = v;
    @(negedge clk); hi_we = 1'b0;
  endtask

  task automatic set_cnt(logic [63:0] v, bit fires = 0, string req = "");
    @(negedge clk);
    count = v;
    if (fires) expect_at(cyc + 1, req);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    while (exp_cyc.size() > 0) begin
      checks++; errors++;
      $display("FAIL %s: missed strobe, actual=0 expected=1 at cycle %0d", exp_req[0], exp_cyc[0]);
      void'(exp_cyc.pop_front()); void'(exp_req.pop_front());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", cmp_val, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1", {63'd0, fire}, 64'd0);
    gbl_en = 1'b1;

    // R2 / R6: one-shot wide
    wr_lo(32'd100);
    wr_hi(32'd0);
    chk("R6", cmp_val, 64'd100);
    set_cnt(64'd0);
    wr_cfg(1, 0, 0, 0);
    set_cnt(64'd99);
    set_cnt(64'd100, 1, "R2");
    set_cnt(64'd101);
    set_cnt(64'd150);
    idle(3);

    // R3: 64-bit signed reach
    wr_cfg(0, 0, 0, 0);
    wr_lo(32'd0);
    wr_hi(32'd1);
    set_cnt(64'h0000_0000_FFFF_FFFF);
    wr_cfg(1, 0, 0, 0);
    idle(2);
    set_cnt(64'h0000_0001_0000_0000, 1, "R3");
    idle(2);

    // R9 / R3: narrow mode truncation and 32-bit signed reach
    wr_cfg(0, 0, 0, 1);
    chk("R9", cmp_val, 64'd0);
    wr_lo(32'h10);
    wr_hi(32'hABCD);
    chk("R9", cmp_val, 64'h10);
    set_cnt(64'h0000_0000_8000_0011);
    wr_cfg(1, 0, 0, 1);
    idle(2);
    set_cnt(64'h0000_0007_0000_0008);
    set_cnt(64'h0000_0007_0000_0010, 1, "R3");
    idle(2);

    // R10: roll-over strobe then real match
    wr_cfg(0, 0, 0, 1);
    set_cnt(64'h0000_0000_FFFF_FFF0);
    wr_cfg(1, 0, 0, 1);
    set_cnt(64'h0000_0000_FFFF_FFFE);
    set_cnt(64'h0000_0000_FFFF_FFFF, 1, "R10");
    set_cnt(64'h0);
    set_cnt(64'h10, 1, "R10");
    set_cnt(64'h20);
    idle(2);

    // R6 / R7 / R4 / R5: periodic wide
    wr_cfg(0, 1, 1, 0);
    wr_lo(32'd1000);
    wr_lo(32'd250);
    chk("R7", cmp_val, 64'd1000);
    set_cnt(64'd0);
    wr_cfg(1, 1, 0, 0);
    set_cnt(64'd999);
    set_cnt(64'd1000, 1, "R4");
    @(negedge clk);
    chk("R4", cmp_val, 64'd1250);
    set_cnt(64'd1100);
    set_cnt(64'd1250, 1, "R4");
    @(negedge clk);
    chk("R4", cmp_val, 64'd1500);
    set_cnt(64'd2300, 1, "R5");
    idle(6);
    chk("R5", cmp_val, 64'd2500);

    // R12: write and match in the same cycle
    @(negedge clk);
    count = 64'd2500;
    lo_we = 1'b1; cmp_wdata = 32'd250;
    expect_at(cyc + 2, "R12");
    @(negedge clk);
    lo_we = 1'b0;
    @(negedge clk);
    chk("R12", cmp_val, 64'd2750);

    // R8: high-half period write drops bit 63
    wr_hi(32'hFFFF_FFFF);
    set_cnt(64'd2750, 1, "R8");
    @(negedge clk);
    chk("R8", cmp_val, 64'h7FFF_FFFF_0000_0BB8);

    // R8 / R4: narrow periodic masking and 32-bit truncated sum
    wr_cfg(0, 1, 1, 1);
    wr_lo(32'hFFFF_FF00);
    wr_lo(32'hFFFF_FF10);
    chk("R7", cmp_val, 64'h0000_0000_FFFF_FF00);
    set_cnt(64'h0000_0000_FFFF_FF00);
    wr_cfg(1, 1, 0, 1, 1, "R4");
    @(negedge clk);
    chk("R8", cmp_val, 64'h0000_0000_7FFF_FE10);

    // R11: enables gate the strobe
    wr_cfg(0, 0, 0, 0);
    wr_lo(32'd500);
    wr_hi(32'd0);
    set_cnt(64'd0);
    wr_cfg(1, 0, 0, 0);
    @(negedge clk); gbl_en = 1'b0;
    set_cnt(64'd600);
    idle(3);
    @(negedge clk); gbl_en = 1'b1;
    expect_at(cyc + 2, "R11");
    idle(3);
    wr_lo(32'd700);
    wr_cfg(0, 0, 0, 0);
    set_cnt(64'd800);
    idle(3);
    chk("R11", cmp_val, 64'd700);
    wr_cfg(1, 0, 0, 0, 1, "R11");
    idle(4);

    finish_run();
  end

endmodule